// File: doc/BRIEF.md
# Dual Auxiliary-Register Address Generator

This block supplies operand addresses for dual-operand data-memory accesses. It holds a file of eight 16-bit pointer registers and two address arithmetic units, named port A and port B. In any cycle each port selects one pointer register and presents its value as a data-memory address. On the following rising edge the port can move that pointer. The step can be plain, it can wrap inside a circular buffer of any length and base, or it can be a bit-reversed step for FFT-style sweeps.

Two circular buffers are configured through a write port that sets each buffer's base and length. The base does not have to be aligned, and the length does not have to be a power of two. A separate load port writes a pointer directly, so software can place a pointer inside a buffer before sweeping it. The address outputs are combinational from the register file. The address that leaves the block in a cycle is always the pointer value before that cycle's update.

Top module: `agen_dual`

## Requirements
- R1: After reset is released, all eight pointers read zero. Both buffers have base zero and length zero. Both address-valid outputs are low while their port-valid inputs are low.
- R2: Each port's address output shows, in the same cycle, the current value of the pointer chosen by its 3-bit select. This holds whatever the state of the port-valid input. Each address-valid output follows its own port-valid input in the same cycle.
- R3: A port whose valid input is high rewrites its selected pointer at the rising edge. Mode codes 0 to 4 give no change (0), +1 (1), -1 (2), +step (3) and -step (4). All of these are taken modulo 2^16.
- R4: Mode 5 is circular add on the buffer chosen by the port's buffer select. It forms n = p + step. If n is at or above base + length, length is subtracted. The comparison uses values that have not been truncated, and the result keeps its low 16 bits.
- R5: Mode 6 is circular subtract. It forms n = p - step as a signed value. If n is below the base, length is added, and the result keeps its low 16 bits.
- R6: A buffer whose length is zero never wraps. In that case modes 5 and 6 behave exactly as modes 3 and 4.
- R7: Mode 7 is bit-reversed add. The step is added to the pointer with the carry moving from bit 15 toward bit 0, so a step of 0x8000 walks 0, 0x8000, 0x4000, 0xC000.
- R8: Suppose both ports are valid, both have a mode other than 0, and both pick the same pointer. Then port A's result is stored and port B's result is dropped. When the two ports pick different pointers, both updates are stored.
- R9: A load write (load enable high) stores its value into the selected pointer at the edge. It takes priority over both ports.
- R10: A configuration write stores the base and length of the buffer it selects at the edge. The new bounds apply from the next cycle on. Without a configuration write, the bounds do not change.
- R11: A port whose valid input is low leaves every pointer unchanged, whatever its mode and step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_vld | input | 1 | Port A request valid |
| a_sel | input | 3 | Port A pointer select |
| a_mode | input | 3 | Port A update mode code |
| a_step | input | 16 | Port A step value |
| a_bsel | input | 1 | Port A circular buffer select |
| b_vld | input | 1 | Port B request valid |
| b_sel | input | 3 | Port B pointer select |
| b_mode | input | 3 | Port B update mode code |
| b_step | input | 16 | Port B step value |
| b_bsel | input | 1 | Port B circular buffer select |
| ld_we | input | 1 | Direct pointer load enable |
| ld_sel | input | 3 | Pointer to load |
| ld_val | input | 16 | Value to load |
| cfg_we | input | 1 | Buffer bounds write enable |
| cfg_bsel | input | 1 | Buffer to configure |
| cfg_start | input | 16 | Buffer base address |
| cfg_len | input | 16 | Buffer length |
| a_addr | output | 16 | Port A address (pointer before update) |
| a_addr_vld | output | 1 | Port A address valid |
| b_addr | output | 16 | Port B address (pointer before update) |
| b_addr_vld | output | 1 | Port B address valid |

## Verification
The assertions check the write-ordering rules on every cycle. They confirm that a load always lands, that port A's result survives a collision with port B, and that pointers and buffer bounds hold still when nothing writes them. They also check that a circular step started inside a buffer, with a step no larger than its length, lands inside the buffer. The exact arithmetic of each mode is shown only by the bench scenarios, which compare every address against a model. These include the wrap at both limits of an unaligned buffer of odd length, the zero-length fallback and the bit-reversed sequence.

// File: rtl/agen_pkg.sv
package agen_pkg;

   typedef enum logic [2:0] {
      M_HOLD = 3'd0,
      M_INC  = 3'd1,
      M_DEC  = 3'd2,
      M_ADD  = 3'd3,
      M_SUB  = 3'd4,
      M_CADD = 3'd5,
      M_CSUB = 3'd6,
      M_RADD = 3'd7
   } agen_mode_e;

   localparam int unsigned AGEN_AW_DEF   = 16;
   localparam int unsigned AGEN_NREG_DEF = 8;
   localparam int unsigned AGEN_NBUF_DEF = 2;

endpackage

// File: rtl/agen_upd.sv
module agen_upd
   import agen_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter bit          BITREV_EN = 1'b1
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] step,
   input  logic [2:0]    mode,
   input  logic [AW-1:0] bstart,
   input  logic [AW-1:0] blen,
   output logic [AW-1:0] nxt
);

   localparam int unsigned EW = AW + 2;

   logic [EW-1:0] cur_x, step_x, lo_x, len_x, hi_x, sum_x, dif_x;
   logic          len_zero;
   logic [AW-1:0] cadd_r, csub_r, radd_r;

   assign cur_x    = {2'b00, cur};
   assign step_x   = {2'b00, step};
   assign lo_x     = {2'b00, bstart};
   assign len_x    = {2'b00, blen};
   assign hi_x     = lo_x + len_x;
   assign sum_x    = cur_x + step_x;
   assign dif_x    = cur_x - step_x;
   assign len_zero = (blen == '0);

   // circular add: wrap down by length once the upper limit is reached
   assign cadd_r = AW'((!len_zero && (sum_x >= hi_x)) ? (sum_x - len_x) : sum_x);

   // circular subtract: signed compare so borrows below zero still wrap up
   assign csub_r = AW'((!len_zero && ($signed(dif_x) < $signed(lo_x))) ? (dif_x + len_x) : dif_x);

   generate
      if (BITREV_EN) begin : g_rev
         function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
            logic [AW-1:0] r;
            for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
            return r;
         endfunction
         logic [AW-1:0] rsum;
         assign rsum   = flip(cur) + flip(step);
         assign radd_r = flip(rsum);
      end else begin : g_norev
         assign radd_r = cur + step;
      end
   endgenerate

   always_comb begin
      unique case (agen_mode_e'(mode))
         M_HOLD:  nxt = cur;
         M_INC:   nxt = cur + AW'(1);
         M_DEC:   nxt = cur - AW'(1);
         M_ADD:   nxt = cur + step;
         M_SUB:   nxt = cur - step;
         M_CADD:  nxt = cadd_r;
         M_CSUB:  nxt = csub_r;
         M_RADD:  nxt = radd_r;
         default: nxt = cur;
      endcase
   end

endmodule

// File: rtl/agen_cbuf.sv
module agen_cbuf #(
   parameter int unsigned AW   = 16,
   parameter int unsigned NBUF = 2,
   localparam int unsigned BW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [BW-1:0]            cfg_bsel,
   input  logic [AW-1:0]            cfg_start,
   input  logic [AW-1:0]            cfg_len,
   output logic [NBUF-1:0][AW-1:0]  start_q,
   output logic [NBUF-1:0][AW-1:0]  len_q
);

   for (genvar k = 0; k < NBUF; k++) begin : g_buf
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            start_q[k] <= '0;
            len_q[k]   <= '0;
         end else if (cfg_we && (cfg_bsel == BW'(k))) begin
            start_q[k] <= cfg_start;
            len_q[k]   <= cfg_len;
         end
      end
   end

   // R10: bounds move only on a configuration write
   p_cfg_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(start_q) && $stable(len_q)));

endmodule

// File: rtl/agen_arfile.sv
module agen_arfile #(
   parameter int unsigned AW   = 16,
   parameter int unsigned NREG = 8,
   localparam int unsigned SW  = $clog2(NREG)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ld_en,
   input  logic [SW-1:0]            ld_idx,
   input  logic [AW-1:0]            ld_data,
   input  logic                     wa_en,
   input  logic [SW-1:0]            wa_idx,
   input  logic [AW-1:0]            wa_data,
   input  logic                     wb_en,
   input  logic [SW-1:0]            wb_idx,
   input  logic [AW-1:0]            wb_data,
   input  logic [SW-1:0]            ra_idx,
   input  logic [SW-1:0]            rb_idx,
   output logic [AW-1:0]            ra_data,
   output logic [AW-1:0]            rb_data
);

   logic [NREG-1:0][AW-1:0] regs;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic hit_ld, hit_a, hit_b;
      assign hit_ld = ld_en && (ld_idx == SW'(i));
      assign hit_a  = wa_en && (wa_idx == SW'(i));
      assign hit_b  = wb_en && (wb_idx == SW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      regs[i] <= '0;
         else if (hit_ld) regs[i] <= ld_data;
         else if (hit_a)  regs[i] <= wa_data;
         else if (hit_b)  regs[i] <= wb_data;
      end
   end

   assign ra_data = regs[ra_idx];
   assign rb_data = regs[rb_idx];

   // R9: a load always lands in its register
   p_ld_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (regs[$past(ld_idx)] == $past(ld_data)));

   // R8: port A beats port B on a shared register
   p_a_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wa_en && wb_en && (wa_idx == wb_idx) && !(ld_en && (ld_idx == wa_idx)))
      |=> (regs[$past(wa_idx)] == $past(wa_data)));

   // R11: nothing writes, nothing moves
   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !wa_en && !wb_en) |=> $stable(regs));

endmodule

// File: rtl/agen_dual.sv
module agen_dual
   import agen_pkg::*;
#(
   parameter int unsigned AW        = AGEN_AW_DEF,
   parameter int unsigned NREG      = AGEN_NREG_DEF,
   parameter int unsigned NBUF      = AGEN_NBUF_DEF,
   parameter bit          BITREV_EN = 1'b1,
   localparam int unsigned SW       = $clog2(NREG),
   localparam int unsigned BW       = (NBUF > 1) ? $clog2(NBUF) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_vld,
   input  logic [SW-1:0] a_sel,
   input  logic [2:0]    a_mode,
   input  logic [AW-1:0] a_step,
   input  logic [BW-1:0] a_bsel,
   input  logic          b_vld,
   input  logic [SW-1:0] b_sel,
   input  logic [2:0]    b_mode,
   input  logic [AW-1:0] b_step,
   input  logic [BW-1:0] b_bsel,
   input  logic          ld_we,
   input  logic [SW-1:0] ld_sel,
   input  logic [AW-1:0] ld_val,
   input  logic          cfg_we,
   input  logic [BW-1:0] cfg_bsel,
   input  logic [AW-1:0] cfg_start,
   input  logic [AW-1:0] cfg_len,
   output logic [AW-1:0] a_addr,
   output logic          a_addr_vld,
   output logic [AW-1:0] b_addr,
   output logic          b_addr_vld
);

   generate
      if (AW < 4)                         begin : g_bad_aw   $error("agen_dual: AW must be at least 4"); end
      if (NREG < 2 || (NREG & (NREG-1)))  begin : g_bad_nreg $error("agen_dual: NREG must be a power of two >= 2"); end
      if (NBUF < 2 || (NBUF & (NBUF-1)))  begin : g_bad_nbuf $error("agen_dual: NBUF must be a power of two >= 2"); end
   endgenerate

   logic [NBUF-1:0][AW-1:0] bstart_q, blen_q;
   logic [AW-1:0] a_cur, b_cur, a_nxt, b_nxt;
   logic [AW-1:0] a_bstart, a_blen, b_bstart, b_blen;
   logic          wa_en, wb_en;
   logic [AW:0]   a_lim;

   agen_cbuf #(.AW(AW), .NBUF(NBUF)) u_cbuf (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_bsel(cfg_bsel), .cfg_start(cfg_start), .cfg_len(cfg_len),
      .start_q(bstart_q), .len_q(blen_q)
   );

   assign a_bstart = bstart_q[a_bsel];
   assign a_blen   = blen_q[a_bsel];
   assign b_bstart = bstart_q[b_bsel];
   assign b_blen   = blen_q[b_bsel];

   agen_upd #(.AW(AW), .BITREV_EN(BITREV_EN)) u_upd_a (
      .cur(a_cur), .step(a_step), .mode(a_mode),
      .bstart(a_bstart), .blen(a_blen), .nxt(a_nxt)
   );

   agen_upd #(.AW(AW), .BITREV_EN(BITREV_EN)) u_upd_b (
      .cur(b_cur), .step(b_step), .mode(b_mode),
      .bstart(b_bstart), .blen(b_blen), .nxt(b_nxt)
   );

   assign wa_en = a_vld && (agen_mode_e'(a_mode) != M_HOLD);
   assign wb_en = b_vld && (agen_mode_e'(b_mode) != M_HOLD);

   agen_arfile #(.AW(AW), .NREG(NREG)) u_arf (
      .clk(clk), .rst_n(rst_n),
      .ld_en(ld_we), .ld_idx(ld_sel), .ld_data(ld_val),
      .wa_en(wa_en), .wa_idx(a_sel), .wa_data(a_nxt),
      .wb_en(wb_en), .wb_idx(b_sel), .wb_data(b_nxt),
      .ra_idx(a_sel), .rb_idx(b_sel),
      .ra_data(a_cur), .rb_data(b_cur)
   );

   assign a_addr     = a_cur;
   assign b_addr     = b_cur;
   assign a_addr_vld = a_vld;
   assign b_addr_vld = b_vld;

   assign a_lim = {1'b0, a_bstart} + {1'b0, a_blen};

   // R4: a circular add started inside the buffer stays inside
   p_circ_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (a_vld && (agen_mode_e'(a_mode) == M_CADD) && (a_blen != '0) && !a_lim[AW] &&
       (a_cur >= a_bstart) && ({1'b0, a_cur} < a_lim) && (a_step <= a_blen))
      |-> ((a_nxt >= a_bstart) && ({1'b0, a_nxt} < a_lim)));

   // R5: a circular subtract started inside the buffer stays inside
   p_circ_stay_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (a_vld && (agen_mode_e'(a_mode) == M_CSUB) && (a_blen != '0) && !a_lim[AW] &&
       (a_cur >= a_bstart) && ({1'b0, a_cur} < a_lim) && (a_step <= a_blen))
      |-> ((a_nxt >= a_bstart) && ({1'b0, a_nxt} < a_lim)));

endmodule

// File: tb/sim_agen_dual.sv
`timescale 1ns/1ps
module sim_agen_dual;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_vld = 0, b_vld = 0, ld_we = 0, cfg_we = 0;
   logic [2:0]  a_sel = 0, b_sel = 0, a_mode = 0, b_mode = 0, ld_sel = 0;
   logic [15:0] a_step = 0, b_step = 0, ld_val = 0, cfg_start = 0, cfg_len = 0;
   logic        a_bsel = 0, b_bsel = 0, cfg_bsel = 0;
   logic [15:0] a_addr, b_addr;
   logic        a_addr_vld, b_addr_vld;

   int checks = 0, errors = 0;
   bit done = 0;
   int m_ar[8];
   int m_st[2];
   int m_ln[2];

   always #4 clk = ~clk;

   agen_dual u0 (
      .clk(clk), .rst_n(rst_n),
      .a_vld(a_vld), .a_sel(a_sel), .a_mode(a_mode), .a_step(a_step), .a_bsel(a_bsel),
      .b_vld(b_vld), .b_sel(b_sel), .b_mode(b_mode), .b_step(b_step), .b_bsel(b_bsel),
      .ld_we(ld_we), .ld_sel(ld_sel), .ld_val(ld_val),
      .cfg_we(cfg_we), .cfg_bsel(cfg_bsel), .cfg_start(cfg_start), .cfg_len(cfg_len),
      .a_addr(a_addr), .a_addr_vld(a_addr_vld), .b_addr(b_addr), .b_addr_vld(b_addr_vld)
   );

   function automatic int rev16(input int v);
      int r = 0;
      for (int i = 0; i < 16; i++) if (v[i]) r |= (1 << (15 - i));
      return r;
   endfunction

   function automatic int calc(input int p, input int md, input int st, input int bs, input int bl);
      int n;
      case (md)
         1: n = p + 1;
         2: n = p - 1;
         3: n = p + st;
         4: n = p - st;
         5: begin n = p + st; if (bl != 0 && n >= bs + bl) n -= bl; end
         6: begin n = p - st; if (bl != 0 && n < bs) n += bl; end
         7: n = rev16((rev16(p) + rev16(st)) & 16'hFFFF);
         default: n = p;
      endcase
      return n & 16'hFFFF;
   endfunction

   task automatic check(input string tag, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
      end
   endtask

   // call at a falling edge with inputs already driven
   task automatic cyc(input string tag);
      int nxt[8];
      int na, nb;
      #1;
      check(tag, "A addr", a_addr, m_ar[a_sel]);
      check(tag, "B addr", b_addr, m_ar[b_sel]);
      check(tag, "A valid", a_addr_vld, a_vld);
      check(tag, "B valid", b_addr_vld, b_vld);
      na = calc(m_ar[a_sel], a_mode, a_step, m_st[a_bsel], m_ln[a_bsel]);
      nb = calc(m_ar[b_sel], b_mode, b_step, m_st[b_bsel], m_ln[b_bsel]);
      nxt = m_ar;
      if (b_vld && b_mode != 0) nxt[b_sel] = nb;
      if (a_vld && a_mode != 0) nxt[a_sel] = na;
      if (ld_we) nxt[ld_sel] = ld_val;
      @(posedge clk);
      m_ar = nxt;
      if (cfg_we) begin m_st[cfg_bsel] = cfg_start; m_ln[cfg_bsel] = cfg_len; end
      @(negedge clk);
   endtask

   task automatic idle();
      a_vld = 0; b_vld = 0; ld_we = 0; cfg_we = 0; a_mode = 0; b_mode = 0;
   endtask

   task automatic load(input int r, input int v, input string tag);
      idle(); ld_we = 1; ld_sel = 3'(r); ld_val = 16'(v); cyc(tag); ld_we = 0;
   endtask

   task automatic opa(input int r, input int md, input int st, input int bsel, input string tag);
      idle(); a_vld = 1; a_sel = 3'(r); a_mode = 3'(md); a_step = 16'(st); a_bsel = 1'(bsel);
      cyc(tag);
   endtask

   task automatic peek(input int r, input int exp, input string tag);
      idle(); a_sel = 3'(r); #1;
      check(tag, "pointer", a_addr, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 8; i++) m_ar[i] = 0;
      m_st[0] = 0; m_st[1] = 0; m_ln[0] = 0; m_ln[1] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state
      for (int i = 0; i < 8; i++) begin
         a_sel = 3'(i); b_sel = 3'(7 - i); cyc("R1");
      end

      // R9 + R3 plain modes
      load(3, 16'h1000, "R9");
      peek(3, 16'h1000, "R9");
      opa(3, 1, 0, 0, "R3");  peek(3, 16'h1001, "R3");
      opa(3, 2, 0, 0, "R3");  opa(3, 2, 0, 0, "R3"); peek(3, 16'h0FFF, "R3");
      opa(3, 3, 5, 0, "R3");  peek(3, 16'h1004, "R3");
      opa(3, 4, 16'h1005, 0, "R3"); peek(3, 16'hFFFF, "R3");
      opa(3, 0, 9, 0, "R3");  peek(3, 16'hFFFF, "R3");

      // R10: buffer 1 at base 100, length 10
      idle(); cfg_we = 1; cfg_bsel = 1; cfg_start = 100; cfg_len = 10; cyc("R10");
      // R4: wrap at the upper limit
      load(1, 107, "R4");
      opa(1, 5, 2, 1, "R4"); peek(1, 109, "R4");
      opa(1, 5, 2, 1, "R4"); peek(1, 101, "R4");
      // R5: wrap at the lower limit
      opa(1, 6, 3, 1, "R5"); peek(1, 108, "R5");
      opa(1, 6, 8, 1, "R5"); peek(1, 100, "R5");
      opa(1, 6, 1, 1, "R5"); peek(1, 109, "R5");
      // R6: buffer 0 has length zero
      load(2, 16'hFFFE, "R6");
      opa(2, 5, 5, 0, "R6"); peek(2, 16'h0003, "R6");
      opa(2, 6, 7, 0, "R6"); peek(2, 16'hFFFC, "R6");
      // R7: bit-reversed walk
      load(4, 0, "R7");
      opa(4, 7, 16'h8000, 0, "R7"); peek(4, 16'h8000, "R7");
      opa(4, 7, 16'h8000, 0, "R7"); peek(4, 16'h4000, "R7");
      opa(4, 7, 16'h8000, 0, "R7"); peek(4, 16'hC000, "R7");
      // R8: collision, then independent updates
      load(5, 50, "R8");
      idle(); a_vld = 1; a_sel = 5; a_mode = 1; b_vld = 1; b_sel = 5; b_mode = 2; cyc("R8");
      peek(5, 51, "R8");
      idle(); a_vld = 1; a_sel = 5; a_mode = 1; b_vld = 1; b_sel = 3; b_mode = 1; cyc("R8");
      peek(5, 52, "R8"); peek(3, 0, "R8");
      // R9: load beats port A
      idle(); ld_we = 1; ld_sel = 5; ld_val = 16'h0777; a_vld = 1; a_sel = 5; a_mode = 1; cyc("R9");
      peek(5, 16'h0777, "R9");
      // R11: invalid port does nothing
      idle(); a_sel = 5; a_mode = 3; a_step = 16'h0100; b_sel = 5; b_mode = 1; cyc("R11");
      peek(5, 16'h0777, "R11");
      // R10: bounds unchanged without write
      load(6, 105, "R10");
      opa(6, 5, 7, 1, "R10"); peek(6, 102, "R10");

      // random mix, every cycle checked against the model (R2/R3..R11)
      for (int n = 0; n < 3000; n++) begin
         a_vld = 1'($urandom_range(0, 3) != 0); b_vld = 1'($urandom_range(0, 3) != 0);
         a_sel = 3'($urandom_range(0, 7)); b_sel = 3'($urandom_range(0, 7));
         a_mode = 3'($urandom_range(0, 7)); b_mode = 3'($urandom_range(0, 7));
         a_step = ($urandom_range(0, 1) != 0) ? 16'($urandom_range(0, 15)) : 16'($urandom);
         b_step = ($urandom_range(0, 1) != 0) ? 16'($urandom_range(0, 15)) : 16'($urandom);
         a_bsel = 1'($urandom_range(0, 1)); b_bsel = 1'($urandom_range(0, 1));
         ld_we = 1'($urandom_range(0, 9) == 0); ld_sel = 3'($urandom_range(0, 7)); ld_val = 16'($urandom);
         cfg_we = 1'($urandom_range(0, 9) == 0); cfg_bsel = 1'($urandom_range(0, 1));
         cfg_start = 16'($urandom); cfg_len = 16'($urandom_range(0, 40));
         cyc("R2");
      end
      idle();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule